// File: doc/BRIEF.md
# Dual-Channel Sample FIFO Controller

This block buffers 8-bit unsigned audio samples for two channels, A and B. Each channel has a 1024-byte store, and a processor fills the stores through a byte-wide register port. A playback engine drains both channels together, one stereo pair per accepted sample. The block tracks a half-full flag and a full/empty flag for each channel. It packs the four flags into one status register that clears when read, and it drives a single level interrupt.

The register port is plain: a write strobe, a read strobe and a 12-bit byte address. Bits 11:10 of the address select the region:

- 0 is channel A storage.
- 1 is channel B storage.
- 2 is the control registers.

In region 2, address bits 1:0 pick the register:

| Offset | Register | Behaviour |
|---|---|---|
| 0 | Engine mode | 2 bits; value 1 selects FIFO mode. |
| 1 | Command | Bit 7 is the flush command; reads return 0. |
| 2 | Status | Read clears all four bits. |
| 3 | Half-full interrupt enables | Bit 0 is channel A, bit 1 is channel B. |

Read data is combinational on `bus_rdata` while `bus_rd` is high. Read side effects happen at the clock edge.

The sample output is a valid/ready stream. `smp_valid` is high exactly while the mode is FIFO mode. A sample is accepted on a clock edge where both `smp_valid` and `smp_ready` are high. The consumer applies back-pressure by holding `smp_ready` low: nothing is popped and the idle timer does not advance. `smp_data` is combinational: bits 7:0 hold the head byte of channel A and bits 15:8 hold the head byte of channel B. A channel that is empty shows 0x80 instead.

Top module: `sfifo_dual_ctrl`

## Requirements
- R1: After reset, the mode is 0, both channels are empty, the status register reads 0, `irq` is low, and the half-full enable register reads 2'b11.
- R2: In mode 1, a write to a channel region pushes the byte whatever the offset. Accepted samples pop both channels in first-in, first-out order. Pointers wrap modulo 1024.
- R3: On an accepted sample, an empty channel presents 0x80 and its level and pointers do not change.
- R4: After each push or pop, a channel's half-full bit becomes 1 when the resulting level is 511 or less, and 0 when it is 512 or more.
- R5: With the channel's enable set, `irq` rises after a lone push that takes the level from 511 to 512, and after a lone pop that takes it from 512 to 511. With the enable clear, these transitions do not raise `irq`.
- R6: A lone push that takes the level from 1022 to 1023, or a lone pop that takes it from 1 to 0, sets the full/empty bit and raises `irq`.
- R7: The status read returns bit 0 = A half-full, bit 1 = A full/empty, bit 2 = B half-full, bit 3 = B full/empty, and bits 7:4 = 0. After the read, all four bits are 0 and `irq` is low unless an event is recorded in the same cycle; such an event wins.
- R8: Writing the command register with bit 7 set empties both channels, clears their pointers and status bits, lowers `irq` and restarts the idle timer.
- R9: A write to the mode register does the same reset as R8 only when the written 2-bit value differs from the current mode. Writing the current value leaves the stored data intact.
- R10: Outside mode 1, a channel write stores the byte at offset `bus_addr[9:0]` of that channel. The byte reads back from the same address. Holding `smp_ready` high moves nothing, because `smp_valid` is low.
- R11: In mode 1, while both channels are empty, the 1024th consecutive accepted sample sets all four status bits and raises `irq`. The count then restarts. Any stored data resets the count.
- R12: A push and a pop on the same channel in the same cycle leave its level unchanged. The flags are evaluated on the resulting level, and neither R5 nor R6 fires.
- R13: A push to a channel that holds 1024 bytes, with no pop in the same cycle, is dropped.
- R14: `smp_valid` is high exactly while the mode register holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register-port write strobe |
| bus_rd | input | 1 | Register-port read strobe |
| bus_addr | input | 12 | Byte address; bits 11:10 select the region |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 when `bus_rd` is low |
| smp_valid | output | 1 | Sample stream valid (mode is 1) |
| smp_ready | input | 1 | Sample stream ready from the consumer |
| smp_data | output | 16 | Channel B head in bits 15:8, channel A head in bits 7:0 |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives a channel across the 511/512 boundary in both directions, with the enable set and then clear. A design that used one threshold for fill and drain would miss an interrupt, or raise one in the wrong cycle. The bench fills a channel past 1023 to 1024 and then pushes once more. A wrong full test would either overwrite the oldest byte, which shows up as a wrong byte during the drain, or stop one byte short. The bench combines a same-cycle push and pop, status reads, and a mode write of the current value. A design that flushed or counted wrongly there would lose data or raise spurious interrupts. It also holds the engine idle for more than a full cycle. A timer that is off by one, or one that runs while data is still stored, raises the idle interrupt a cycle early or late.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  localparam int unsigned NCH = 2;

  typedef enum logic [1:0] {
    ENG_OFF  = 2'd0,
    ENG_FIFO = 2'd1,
    ENG_WAVE = 2'd2,
    ENG_RSVD = 2'd3
  } eng_mode_e;

  localparam logic [7:0] MID_SCALE = 8'h80;

  // Register offsets inside the control region
  localparam logic [1:0] RO_MODE = 2'd0;
  localparam logic [1:0] RO_CMD  = 2'd1;
  localparam logic [1:0] RO_STAT = 2'd2;
  localparam logic [1:0] RO_HEN  = 2'd3;

  localparam logic [1:0] REGION_CTRL = 2'd2;

  // Per-channel status pair: fe in the upper bit, hf in the lower bit
  typedef struct packed {
    logic fe;
    logic hf;
  } ch_stat_t;

endpackage

// File: rtl/sfifo_chan.sv
module sfifo_chan
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH_LOG2 = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  push,
  input  logic [7:0]            push_data,
  input  logic                  dir_we,
  input  logic [DEPTH_LOG2-1:0] dir_addr,
  input  logic [7:0]            dir_data,
  input  logic                  pop_req,
  input  logic [DEPTH_LOG2-1:0] peek_addr,
  output logic [7:0]            peek_data,
  output logic [7:0]            pop_data,
  output logic [DEPTH_LOG2:0]   level,
  input  logic                  stat_clr,
  input  logic                  stat_set_all,
  input  logic                  half_irq_en,
  output ch_stat_t              stat,
  output logic                  irq_evt
);

  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;
  localparam int unsigned LW    = DEPTH_LOG2 + 1;
  localparam logic [LW-1:0] LV_MAX   = LW'(DEPTH);
  localparam logic [LW-1:0] LV_TOP   = LW'(DEPTH - 1);
  localparam logic [LW-1:0] LV_HALF  = LW'(DEPTH / 2);
  localparam logic [LW-1:0] LV_BELOW = LW'(DEPTH / 2 - 1);

  logic [7:0]            mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0]         level_q, level_d;
  ch_stat_t              stat_q, stat_d;
  logic                  pop_ok, push_ok, lone_push, lone_pop;
  logic                  half_hit, fe_hit;

  assign pop_ok    = pop_req && (level_q != '0);
  assign push_ok   = push && ((level_q != LV_MAX) || pop_ok);
  assign lone_push = push_ok && !pop_ok;
  assign lone_pop  = pop_ok && !push_ok;

  always_comb begin
    level_d = level_q;
    if (lone_push) level_d = level_q + LW'(1);
    if (lone_pop)  level_d = level_q - LW'(1);
  end

  assign half_hit = half_irq_en &&
                    ((lone_push && level_d == LV_HALF) ||
                     (lone_pop  && level_d == LV_BELOW));
  assign fe_hit   = (lone_push && level_d == LV_TOP) ||
                    (lone_pop  && level_d == '0);

  always_comb begin
    stat_d = stat_q;
    if (stat_clr) stat_d = '0;
    if (push_ok || pop_ok) stat_d.hf = (level_d <= LV_BELOW);
    if (fe_hit) stat_d.fe = 1'b1;
    if (stat_set_all) stat_d = '{fe: 1'b1, hf: 1'b1};
  end

  assign irq_evt = !flush && (half_hit || fe_hit || stat_set_all);

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= push_data;
    else if (dir_we)       mem[dir_addr] <= dir_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
      stat_q  <= '0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
      stat_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + DEPTH_LOG2'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + DEPTH_LOG2'(1);
      level_q <= level_d;
      stat_q  <= stat_d;
    end
  end

  assign pop_data  = (level_q != '0) ? mem[rd_ptr] : MID_SCALE;
  assign peek_data = mem[peek_addr];
  assign level     = level_q;
  assign stat      = stat_q;

endmodule

// File: rtl/sfifo_idle_timer.sv
module sfifo_idle_timer #(
  parameter int unsigned CYCLE = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic idle,
  input  logic tick,
  output logic fire
);

  localparam int unsigned CW = (CYCLE < 2) ? 1 : $clog2(CYCLE);
  localparam logic [CW-1:0] LAST = CW'(CYCLE - 1);

  logic [CW-1:0] cnt_q;

  assign fire = idle && tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (flush || !idle)  cnt_q <= '0;
    else if (tick)            cnt_q <= fire ? '0 : cnt_q + CW'(1);
  end

endmodule

// File: rtl/sfifo_dual_ctrl.sv
module sfifo_dual_ctrl
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH_LOG2 = 10,
  parameter int unsigned IDLE_CYCLE = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DEPTH_LOG2+1:0] bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic                  smp_valid,
  input  logic                  smp_ready,
  output logic [NCH*8-1:0]      smp_data,
  output logic                  irq
);

  localparam int unsigned LW = DEPTH_LOG2 + 1;

  logic [1:0]            region;
  logic [DEPTH_LOG2-1:0] offs;
  logic [1:0]            roff;
  logic                  is_ctrl;
  eng_mode_e             mode_q;
  logic [NCH-1:0]        hen_q;
  logic                  irq_q;
  logic                  flush, stat_rd, fifo_mode, hs, idle, fire;

  ch_stat_t              stat [NCH];
  logic [LW-1:0]         lvl  [NCH];
  logic [7:0]            peek [NCH];
  logic [7:0]            popd [NCH];
  logic [NCH-1:0]        evt;
  logic [NCH-1:0]        empty_v;

  assign region  = bus_addr[DEPTH_LOG2+1 -: 2];
  assign offs    = bus_addr[DEPTH_LOG2-1:0];
  assign roff    = bus_addr[1:0];
  assign is_ctrl = (region == REGION_CTRL);

  assign flush   = bus_wr && is_ctrl &&
                   ((roff == RO_MODE && bus_wdata[1:0] != mode_q) ||
                    (roff == RO_CMD  && bus_wdata[7]));
  assign stat_rd = bus_rd && is_ctrl && (roff == RO_STAT);

  assign fifo_mode = (mode_q == ENG_FIFO);
  assign smp_valid = fifo_mode;
  assign hs        = smp_valid && smp_ready;
  assign idle      = &empty_v;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic ch_sel;
      assign ch_sel     = bus_wr && (region == 2'(g));
      assign empty_v[g] = (lvl[g] == '0);

      sfifo_chan #(.DEPTH_LOG2(DEPTH_LOG2)) u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .push        (ch_sel && fifo_mode),
        .push_data   (bus_wdata),
        .dir_we      (ch_sel && !fifo_mode),
        .dir_addr    (offs),
        .dir_data    (bus_wdata),
        .pop_req     (hs && !flush),
        .peek_addr   (offs),
        .peek_data   (peek[g]),
        .pop_data    (popd[g]),
        .level       (lvl[g]),
        .stat_clr    (stat_rd),
        .stat_set_all(fire),
        .half_irq_en (hen_q[g]),
        .stat        (stat[g]),
        .irq_evt     (evt[g])
      );

      assign smp_data[g*8 +: 8] = popd[g];
    end
  endgenerate

  sfifo_idle_timer #(.CYCLE(IDLE_CYCLE)) u_idle (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(flush),
    .idle (idle),
    .tick (hs),
    .fire (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ENG_OFF;
      hen_q  <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (bus_wr && is_ctrl && roff == RO_MODE) mode_q <= eng_mode_e'(bus_wdata[1:0]);
      if (bus_wr && is_ctrl && roff == RO_HEN)  hen_q  <= bus_wdata[NCH-1:0];
      if (flush)        irq_q <= 1'b0;
      else if (|evt)    irq_q <= 1'b1;
      else if (stat_rd) irq_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (region)
        2'd0: bus_rdata = peek[0];
        2'd1: bus_rdata = peek[1];
        REGION_CTRL: begin
          case (roff)
            RO_MODE: bus_rdata = {6'b0, mode_q};
            RO_STAT: bus_rdata = {4'b0, stat[1], stat[0]};
            RO_HEN:  bus_rdata = {{(8-NCH){1'b0}}, hen_q};
            default: bus_rdata = '0;
          endcase
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/sfifo_dual_ctrl_chk.sv
module sfifo_dual_ctrl_chk #(
  parameter int unsigned DEPTH_LOG2 = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [DEPTH_LOG2+1:0] bus_addr,
  input logic                  cmd_flush_bit,
  input logic                  smp_valid,
  input logic                  smp_ready,
  input logic                  irq,
  input logic [DEPTH_LOG2:0]   lvl_a,
  input logic [DEPTH_LOG2:0]   lvl_b
);

  localparam logic [DEPTH_LOG2:0] FULL = (DEPTH_LOG2+1)'(1 << DEPTH_LOG2);

  logic [1:0] rg;
  logic       hs, push_a, ctrl_wr;

  assign rg      = bus_addr[DEPTH_LOG2+1 -: 2];
  assign hs      = smp_valid && smp_ready;
  assign push_a  = bus_wr && rg == 2'd0 && smp_valid;
  assign ctrl_wr = bus_wr && rg == 2'd2;

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_addr[1:0] == 2'd1 && cmd_flush_bit) |=> (lvl_a == '0 && lvl_b == '0));

  // R3
  empty_pop_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && lvl_a == '0 && !push_a && !ctrl_wr) |=> (lvl_a == '0));

  // R13
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_a == FULL && !hs && !ctrl_wr) |=> (lvl_a == FULL));

  // R12
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_a && hs && lvl_a != '0) |=> $stable(lvl_a));

  // R7
  stat_read_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rg == 2'd2 && bus_addr[1:0] == 2'd2 && !hs && !bus_wr) |=> !irq);

endmodule

bind sfifo_dual_ctrl sfifo_dual_ctrl_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .cmd_flush_bit(bus_wdata[7]),
  .smp_valid    (smp_valid),
  .smp_ready    (smp_ready),
  .irq          (irq),
  .lvl_a        (lvl[0]),
  .lvl_b        (lvl[1])
);

// File: tb/tb_sfifo_dual_ctrl.sv
module tb_sfifo_dual_ctrl;

  localparam int LEN = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, smp_ready = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        smp_valid, irq;
  logic [15:0] smp_data;

  always #2 clk = ~clk;

  sfifo_dual_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data), .irq(irq)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // behavioural model
  logic [7:0] mq [2][$];
  logic [7:0] mmem [2][1024];
  int         wp [2];
  bit         m_hf [2], m_fe [2];
  bit         m_irq;
  logic [1:0] m_mode, m_en;
  int         m_tmr;

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(bit wr, bit rd, logic [11:0] a, logic [7:0] d, bit rdy);
    bit hs, fl, srd, rh, idle, fire, ev, push, pop, acc;
    int old;
    logic [7:0] exp_rd;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; smp_ready = rdy;
    #1;
    chk("irq", {15'b0, irq}, {15'b0, m_irq});
    chk("valid", {15'b0, smp_valid}, {15'b0, m_mode == 2'd1}); // R14
    if (m_mode == 2'd1) begin
      chk("data A", {8'h0, smp_data[7:0]},  {8'h0, (mq[0].size() != 0) ? mq[0][0] : 8'h80});
      chk("data B", {8'h0, smp_data[15:8]}, {8'h0, (mq[1].size() != 0) ? mq[1][0] : 8'h80});
    end
    rh = (a[11:10] == 2'd2);
    if (rd) begin
      exp_rd = 8'h00;
      if (a[11:10] < 2) exp_rd = mmem[a[10]][a[9:0]];
      else if (rh) begin
        case (a[1:0])
          2'd0: exp_rd = {6'b0, m_mode};
          2'd2: exp_rd = {4'b0, m_fe[1], m_hf[1], m_fe[0], m_hf[0]};
          2'd3: exp_rd = {6'b0, m_en};
          default: exp_rd = 8'h00;
        endcase
      end
      chk("rdata", {8'h0, bus_rdata}, {8'h0, exp_rd});
    end
    // model edge
    hs  = rdy && m_mode == 2'd1;
    fl  = wr && rh && ((a[1:0] == 0 && d[1:0] != m_mode) || (a[1:0] == 1 && d[7]));
    srd = rd && rh && a[1:0] == 2'd2;
    if (fl) begin
      for (int c = 0; c < 2; c++) begin
        mq[c].delete(); wp[c] = 0; m_hf[c] = 0; m_fe[c] = 0;
      end
      m_irq = 0; m_tmr = 0;
    end else begin
      idle = mq[0].size() == 0 && mq[1].size() == 0;
      fire = hs && idle && m_tmr == LEN - 1;
      if (!idle) m_tmr = 0;
      else if (hs) m_tmr = fire ? 0 : m_tmr + 1;
      ev = 0;
      for (int c = 0; c < 2; c++) begin
        push = wr && a[11:10] == 2'(c) && m_mode == 2'd1;
        if (wr && a[11:10] == 2'(c) && m_mode != 2'd1) mmem[c][a[9:0]] = d;
        old = mq[c].size();
        pop = hs && old != 0;
        acc = push && (old < 1024 || pop);
        if (pop) void'(mq[c].pop_front());
        if (acc) begin
          mq[c].push_back(d); mmem[c][wp[c]] = d; wp[c] = (wp[c] + 1) % 1024;
        end
        if (srd) begin m_hf[c] = 0; m_fe[c] = 0; end
        if (acc || pop) begin
          int nw = mq[c].size();
          m_hf[c] = (nw <= 511);
          if (m_en[c] && ((nw == 512 && old == 511) || (nw == 511 && old == 512))) ev = 1;
          if ((nw == 1023 && old == 1022) || (nw == 0 && old == 1)) begin
            m_fe[c] = 1; ev = 1;
          end
        end
        if (fire) begin m_hf[c] = 1; m_fe[c] = 1; ev = 1; end
      end
      if (ev) m_irq = 1;
      else if (srd) m_irq = 0;
    end
    if (wr && rh && a[1:0] == 2'd0) m_mode = d[1:0];
    if (wr && rh && a[1:0] == 2'd3) m_en = d[1:0];
    @(negedge clk);
  endtask

  task automatic wreg(logic [1:0] o, logic [7:0] v); step(1, 0, {2'd2, 8'h0, o}, v, 0); endtask
  task automatic rreg(logic [1:0] o);               step(0, 1, {2'd2, 8'h0, o}, 8'h0, 0); endtask
  task automatic push(int c, logic [7:0] v);         step(1, 0, {2'(c), 10'(c * 37)}, v, 0); endtask
  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) step(0, 0, 12'h0, 8'h0, rdy);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      wp[c] = 0; m_hf[c] = 0; m_fe[c] = 0;
      for (int i = 0; i < 1024; i++) mmem[c][i] = 'x;
    end
    m_irq = 0; m_mode = 0; m_en = 2'b11; m_tmr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    cur_req = "R1";
    rreg(0); rreg(2); rreg(3); rreg(1);
    // R9: mode change flushes; same-value write keeps data
    cur_req = "R9";
    wreg(0, 8'h01);
    push(0, 8'h11); push(0, 8'h22); push(1, 8'h33);
    wreg(0, 8'h01);
    rreg(0);
    // R2: FIFO order on both channels
    cur_req = "R2";
    push(0, 8'h44);
    idle(3, 1);
    // R3: pops on empty channels give mid-scale
    cur_req = "R3";
    idle(4, 1);
    rreg(2);
    // R12: push and pop in the same cycle
    cur_req = "R12";
    push(0, 8'h55); push(0, 8'h66);
    step(1, 0, 12'h000, 8'h77, 1);
    step(1, 0, 12'h000, 8'h88, 1);
    rreg(2);
    idle(4, 1);
    rreg(2);
    // R4, R5, R6, R13: fill channel A past full, then drain
    cur_req = "R5";
    for (int i = 0; i < 512; i++) push(0, 8'(i * 7 + 1));
    rreg(2); rreg(2);
    cur_req = "R6";
    for (int i = 512; i < 1023; i++) push(0, 8'(i * 7 + 1));
    rreg(2);
    push(0, 8'hE1);
    cur_req = "R13";
    push(0, 8'hE2); push(0, 8'hE3);
    rreg(2);
    cur_req = "R4";
    for (int i = 0; i < 512; i++) step(0, 0, 12'h0, 8'h0, 1);
    rreg(2);
    step(0, 0, 12'h0, 8'h0, 1);
    rreg(2);
    cur_req = "R6";
    idle(515, 1);
    rreg(2);
    // R5: half-full interrupt disabled on A, enabled on B
    cur_req = "R5";
    wreg(3, 8'h02); rreg(3);
    for (int i = 0; i < 520; i++) begin push(0, 8'(i)); push(1, 8'(i ^ 8'h5A)); end
    rreg(2);
    wreg(3, 8'h03);
    // R8: flush command
    cur_req = "R8";
    wreg(1, 8'h80);
    rreg(2);
    idle(3, 1);
    wreg(1, 8'h7F);
    // R10: direct storage outside FIFO mode
    cur_req = "R10";
    wreg(0, 8'h02);
    step(1, 0, 12'h005, 8'h3C, 1);
    step(1, 0, 12'h7FF, 8'hA5, 1);
    step(0, 1, 12'h005, 8'h0, 1);
    step(0, 1, 12'h7FF, 8'h0, 1);
    wreg(0, 8'h00);
    step(1, 0, 12'h3FF, 8'h96, 0);
    step(0, 1, 12'h3FF, 8'h0, 0);
    step(0, 1, 12'hC00, 8'h0, 0);
    // R11: idle engine raises periodic interrupt
    cur_req = "R11";
    wreg(0, 8'h01);
    idle(LEN - 1, 1);
    rreg(2);
    idle(1, 1);
    rreg(2);
    idle(200, 0);
    idle(LEN - 1, 1);
    push(1, 8'hAB);
    idle(LEN, 1);
    rreg(2);
    idle(LEN, 1);
    // R7: status read versus same-cycle event
    cur_req = "R7";
    push(0, 8'h01);
    step(0, 1, 12'h802, 8'h0, 1);
    rreg(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule